// File: doc/BRIEF.md
# Burst Address Counter with Selectable Beat Order

This block produces the access address for a four-beat burst inside a synchronous memory. A load cycle captures the whole external address and starts a burst. Each later advance cycle moves only the two lowest address bits to the next beat; the upper bits stay as loaded. A static order strap picks the sequence. Linear order counts upward modulo four from the starting offset. Interleaved order combines the starting offset with a rising beat count by exclusive-or.

All state changes only on clock edges where the active-low clock enable is asserted. When clock enable is deasserted, the cycle simply stretches and every register keeps its value. A load made while the chip-select status is low leaves the counter idle. Advance cycles then have no effect until another load arrives with chip select high. The memory array and data path sit outside this block. They read `acc_addr` during the cycle after each accepted command.

Top module: `burst_addr_ctr`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `acc_addr` is zero and `acc_active` is 0.
- R2: An edge with `clk_en_n`=0 and `adv_ld`=0 is a load. After it, `acc_addr` equals the `ext_addr` sampled at that edge and the beat count restarts at zero. A load replaces a burst that is still running.
- R3: With `mode_il`=0 (linear), after k accepted advances following a load with start offset s = `ext_addr[1:0]`, `acc_addr[1:0]` equals (s + k) mod 4.
- R4: With `mode_il`=1 (interleaved), after k accepted advances following a load with start offset s, `acc_addr[1:0]` equals s XOR (k mod 4).
- R5: An advance never changes `acc_addr[ADDR_W-1:2]`.
- R6: On an edge with `clk_en_n`=1, `acc_addr` and `acc_active` keep their values, whatever `adv_ld`, `sel` and `ext_addr` are. This applies to both load and advance requests.
- R7: After a load, `acc_active` equals the `sel` value sampled at that load. While `acc_active` is 0, an advance (`clk_en_n`=0, `adv_ld`=1) leaves `acc_addr` unchanged. Only a load with `sel`=1 starts a new burst.
- R8: In either order, the fourth advance after a load returns `acc_addr` to the loaded address, and the burst keeps repeating with period four.
- R9: Every accepted advance while active toggles `acc_addr[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high stretches the current cycle |
| adv_ld | input | 1 | 1 = advance the burst, 0 = load a new address |
| sel | input | 1 | Chip-select status sampled on a load; 1 = selected |
| mode_il | input | 1 | Static order strap: 1 = interleaved, 0 = linear |
| ext_addr | input | ADDR_W | External address captured on a load |
| acc_addr | output | ADDR_W | Current access address |
| acc_active | output | 1 | A burst started by a selected load is in progress |

## Verification
The checker assumes that `mode_il` only changes while no burst is running, so that an advance is never judged against a different order. It also assumes that the control inputs are never unknown once reset is released. The stimulus sets the order strap only before a load and keeps it fixed through all beats and stalls. Every control input is always driven to a known level. Stalled cycles deliberately carry load requests, different addresses and toggled select values, so that the hold property is tested against inputs that would otherwise change the state.

// File: rtl/bac_pkg.sv
package bac_pkg;

    typedef enum logic [1:0] {
        BAC_HOLD = 2'd0,
        BAC_LOAD = 2'd1,
        BAC_STEP = 2'd2,
        BAC_PARK = 2'd3
    } bac_cmd_e;

    localparam int unsigned BAC_BURST_W = 2;

endpackage

// File: rtl/bac_cmd_decode.sv
module bac_cmd_decode
    import bac_pkg::*;
(
    input  logic     clk_en_n,
    input  logic     adv_ld,
    input  logic     active_q,
    output bac_cmd_e cmd
);
    always_comb begin
        if (clk_en_n) begin
            cmd = BAC_HOLD;
        end else if (!adv_ld) begin
            cmd = BAC_LOAD;
        end else if (active_q) begin
            cmd = BAC_STEP;
        end else begin
            cmd = BAC_PARK;
        end
    end
endmodule

// File: rtl/bac_order.sv
module bac_order #(
    parameter int unsigned BURST_W = 2
) (
    input  logic               mode_il,
    input  logic [BURST_W-1:0] start,
    input  logic [BURST_W-1:0] beat,
    output logic [BURST_W-1:0] low
);
    logic [BURST_W-1:0] lin_low;
    logic [BURST_W-1:0] il_low;

    // Linear order wraps inside the burst window; interleaved order uses XOR per bit.
    assign lin_low = start + beat;

    for (genvar g = 0; g < BURST_W; g++) begin : g_xor
        assign il_low[g] = start[g] ^ beat[g];
    end

    assign low = mode_il ? il_low : lin_low;
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
    import bac_pkg::*;
#(
    parameter int unsigned ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              adv_ld,
    input  logic              sel,
    input  logic              mode_il,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_active
);
    localparam int unsigned BW   = BAC_BURST_W;
    localparam int unsigned UP_W = ADDR_W - BW;

    typedef struct packed {
        logic [UP_W-1:0] upper;
        logic [BW-1:0]   start;
        logic [BW-1:0]   beat;
        logic            active;
    } bac_state_t;

    bac_state_t st_d, st_q;
    bac_cmd_e   cmd;
    logic [BW-1:0] low_bits;

    bac_cmd_decode u_dec (
        .clk_en_n (clk_en_n),
        .adv_ld   (adv_ld),
        .active_q (st_q.active),
        .cmd      (cmd)
    );

    bac_order #(.BURST_W(BW)) u_order (
        .mode_il (mode_il),
        .start   (st_q.start),
        .beat    (st_q.beat),
        .low     (low_bits)
    );

    always_comb begin
        st_d = st_q;
        unique case (cmd)
            BAC_LOAD: begin
                st_d.upper  = ext_addr[ADDR_W-1:BW];
                st_d.start  = ext_addr[BW-1:0];
                st_d.beat   = '0;
                st_d.active = sel;
            end
            BAC_STEP: begin
                st_d.beat = st_q.beat + 1'b1;
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_addr   = {st_q.upper, low_bits};
    assign acc_active = st_q.active;
endmodule

// File: rtl/bac_checker.sv
module bac_checker #(
    parameter int unsigned ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n,
    input logic              adv_ld,
    input logic              sel,
    input logic              mode_il,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_active
);
    p_reset_r1: assert property (@(posedge clk) !rst_n |-> (acc_addr == '0 && !acc_active));

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld) |=> acc_addr == $past(ext_addr));

    p_linear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld && acc_active && !mode_il) |=>
        (mode_il || acc_addr[1:0] == 2'($past(acc_addr[1:0]) + 2'd1)));

    p_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld) |=> acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2]));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(acc_addr) && $stable(acc_active)));

    p_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld) |=> acc_active == $past(sel));

    p_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld && !acc_active) |=> ($stable(acc_addr) && !acc_active));

    p_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld && acc_active) |=> acc_addr[0] != $past(acc_addr[0]));
endmodule

bind burst_addr_ctr bac_checker #(.ADDR_W(ADDR_W)) u_bac_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en_n   (clk_en_n),
    .adv_ld     (adv_ld),
    .sel        (sel),
    .mode_il    (mode_il),
    .ext_addr   (ext_addr),
    .acc_addr   (acc_addr),
    .acc_active (acc_active)
);

// File: tb/test_burst_addr_ctr.sv
`timescale 1ns/1ps
module test_burst_addr_ctr;
    localparam int AW = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_en_n = 1'b1;
    logic adv_ld = 1'b0;
    logic sel = 1'b0;
    logic mode_il = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] acc_addr;
    logic acc_active;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_ctr #(.ADDR_W(AW)) i_burst_addr_ctr (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_ld(adv_ld),
        .sel(sel), .mode_il(mode_il), .ext_addr(ext_addr),
        .acc_addr(acc_addr), .acc_active(acc_active)
    );

    // Vector: {mode, start[1:0], upper[16:0]}
    localparam logic [19:0] VEC [8] = '{
        {1'b0, 2'd0, 17'h1A5C3}, {1'b0, 2'd1, 17'h00F0F},
        {1'b0, 2'd2, 17'h1FFFF}, {1'b0, 2'd3, 17'h12345},
        {1'b1, 2'd0, 17'h0ACE1}, {1'b1, 2'd1, 17'h15555},
        {1'b1, 2'd2, 17'h00000}, {1'b1, 2'd3, 17'h0BEEF}
    };

    task automatic chk(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive at the falling edge; the next falling edge sees the updated state.
    task automatic cyc(input logic ce_n, input logic al, input logic s, input logic [AW-1:0] a);
        clk_en_n = ce_n; adv_ld = al; sel = s; ext_addr = a;
        @(negedge clk);
    endtask

    function automatic logic [1:0] exp_low(input logic m, input logic [1:0] s, input int k);
        logic [1:0] kk = 2'(k);
        return m ? (s ^ kk) : 2'(s + kk);
    endfunction

    initial begin
        #(5ns * 200000);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] base;
        @(negedge clk);
        // R1 reset state
        chk("R1 addr in reset", acc_addr, '0);
        chk("R1 active in reset", {18'd0, acc_active}, '0);
        @(negedge clk); rst_n = 1'b1;
        cyc(1'b1, 1'b1, 1'b1, 19'h7FFFF);
        chk("R1 addr after reset", acc_addr, '0);

        for (int v = 0; v < 8; v++) begin
            mode_il = VEC[v][19];
            base = {VEC[v][16:0], VEC[v][18:17]};
            cyc(1'b0, 1'b0, 1'b1, base);
            chk("R2 load", acc_addr, base);
            chk("R7 active after load", {18'd0, acc_active}, 19'd1);
            for (int k = 1; k <= 6; k++) begin
                if (k == 2) begin
                    cyc(1'b1, 1'b0, 1'b0, ~base);
                    chk("R6 stall holds addr", acc_addr, {base[AW-1:2], exp_low(mode_il, base[1:0], k-1)});
                    chk("R6 stall holds active", {18'd0, acc_active}, 19'd1);
                end
                cyc(1'b0, 1'b1, 1'b0, ~base);
                chk(mode_il ? "R4 interleaved beat" : "R3 linear beat",
                    acc_addr, {base[AW-1:2], exp_low(mode_il, base[1:0], k)});
                if (k == 4) chk("R8 wrap to start", acc_addr, base);
            end
        end

        // R7 deselected load parks the counter
        mode_il = 1'b0;
        cyc(1'b0, 1'b0, 1'b0, 19'h2_4681);
        chk("R7 deselect active", {18'd0, acc_active}, '0);
        chk("R7 deselect addr", acc_addr, 19'h2_4681);
        cyc(1'b0, 1'b1, 1'b1, 19'h0);
        cyc(1'b0, 1'b1, 1'b1, 19'h0);
        chk("R7 advance while parked", acc_addr, 19'h2_4681);
        chk("R7 still parked", {18'd0, acc_active}, '0);
        cyc(1'b0, 1'b0, 1'b1, 19'h3_0002);
        cyc(1'b0, 1'b1, 1'b0, 19'h0);
        chk("R7 restart by load", acc_addr, 19'h3_0003);

        // R2 load during a running burst restarts it
        cyc(1'b0, 1'b0, 1'b1, 19'h1_1111);
        chk("R2 reload mid-burst", acc_addr, 19'h1_1111);
        cyc(1'b0, 1'b1, 1'b1, 19'h0);
        chk("R3 beat after reload", acc_addr, 19'h1_1112);

        // R6 load request during stall is ignored
        cyc(1'b1, 1'b0, 1'b0, 19'h5_5555);
        chk("R6 stalled load ignored", acc_addr, 19'h1_1112);
        chk("R6 stalled sel ignored", {18'd0, acc_active}, 19'd1);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule